// File: doc/BRIEF.md
# Power-On Strap Latch and Frequency Code Select

A clock generator shares a handful of pads between two jobs. While the chip is in power-on reset, each pad is a configuration input: an external pull resistor sets its level. Once reset is over, the same pad drives a clock. This block runs that hand-over. After the reset input is released it waits through a fixed strap window, then stores the five pad levels in a latch. It keeps the pad drivers disabled for one further reference cycle and only then enables them. Because of this, the input and output phases never overlap.

Four of the latched levels form the hardware frequency code. The fifth picks between the 24 MHz and 48 MHz rates for the USB-rate output. A control-register bit selects where the active 4-bit frequency code comes from:

- the latched straps, or
- a software code gathered from scattered bits of the same register.

Any change of the code or of its source appears at a reference-clock edge together with a one-cycle update pulse, which the downstream synthesizer logic uses to retune. The block also forwards the spread-spectrum enable and spread-mode bits and the hub-clock rate select. It exposes an inverted copy of the hardware code for register readback.

Top module: `strap_freq_select`

## Requirements
- R1: `pad_oe_o` is 0 during reset and throughout the strap window. It rises after exactly `RST_CYCLES`+1 rising edges of `clk_ref_i` counted from reset release, and stays 1 until the next reset.
- R2: The latch stores `pad_level_i` as sampled at the `RST_CYCLES`-th edge after reset release. Later pad changes do not affect `fs_readback_o`, `usb_sel_o` or the hardware code.
- R3: `fs_readback_o[i]` is the inverse of latched strap bit i, for i = 0..3. Here `pad_level_i[3:0]` carries the frequency straps with bit 3 as the most significant bit of the code.
- R4: While `ctrl0_i[3]` is 0, `freq_code_o` equals the latched straps `pad_level_i[3:0]`, and `code_src_sw_o` is 0.
- R5: While `ctrl0_i[3]` is 1, `freq_code_o` equals {`ctrl0_i[2]`, `ctrl0_i[6]`, `ctrl0_i[5]`, `ctrl0_i[4]`}, with bit 2 as the most significant bit, and `code_src_sw_o` is 1.
- R6: A change of the selected code or of the source bit appears on `freq_code_o`/`code_src_sw_o` one edge after the control input changes. `code_upd_o` is 1 for exactly the cycles in which the code or the source differs from the previous cycle. A control change that alters neither gives no pulse.
- R7: `spread_en_o` follows `ctrl0_i[1]` and `spread_down_o` follows `ctrl0_i[7]`, each one edge later (1 = down spread, 0 = center spread).
- R8: `hub_sel_o` follows `hub_sel_i` one edge later. `usb_sel_o` equals latched strap bit `pad_level_i[4]`.
- R9: After reset, `freq_code_o` and `code_upd_o` are 0 until the pads are enabled. The first enabled cycle already shows the selected code and has no update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous assert |
| pad_level_i | input | 5 | Levels sensed on the shared pads ([3:0] frequency straps, [4] USB-rate strap) |
| ctrl0_i | input | 7 | Control register bits 7:1 |
| hub_sel_i | input | 1 | Hub clock rate select |
| pad_oe_o | output | 1 | Output enable for the shared pads |
| freq_code_o | output | 4 | Active frequency code |
| code_src_sw_o | output | 1 | 1 when the code comes from the register |
| code_upd_o | output | 1 | One-cycle pulse on a code or source change |
| spread_en_o | output | 1 | Spread-spectrum enable |
| spread_down_o | output | 1 | Spread mode, 1 = down spread |
| hub_sel_o | output | 1 | Registered hub clock rate select |
| usb_sel_o | output | 1 | Latched 24/48 MHz select strap |
| fs_readback_o | output | 4 | Inverted latched frequency straps |

## Verification
The two functions that can collide are the source switch and the software code change. Both are driven by the same control input, so flipping bit 3 while also altering bits 2 and 6:4 lands both in one edge.

The bench provokes this in directed steps, including one in which the software code equals the strap code so that only the source changes. Random control bytes are held for one to three cycles. Each step is judged against a bench model: one update pulse, and the code taken from the new source.

A second collision is the latch closing while the pads still move. The pad level is changed one cycle before and one cycle after the capture edge, and the captured value must be the one in between.

// File: rtl/strap_freq_pkg.sv
package strap_freq_pkg;

    localparam int FS_W    = 4;
    localparam int STRAP_W = FS_W + 1;

    typedef enum logic [1:0] {
        PH_SAMPLE = 2'd0,
        PH_GAP    = 2'd1,
        PH_RUN    = 2'd2
    } phase_e;

    // positions inside the control register that the selector decodes
    localparam int CB_SPREAD_EN = 1;
    localparam int CB_SW_MSB    = 2;
    localparam int CB_SRC_SEL   = 3;
    localparam int CB_SW_B0     = 4;
    localparam int CB_SW_B1     = 5;
    localparam int CB_SW_B2     = 6;
    localparam int CB_SPREAD_DN = 7;

endpackage

// File: rtl/strap_seq.sv
module strap_seq
    import strap_freq_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] pins_i,
    output phase_e             phase_o,
    output logic [STRAP_W-1:0] latch_o,
    output logic               oe_o
);

    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [STRAP_W-1:0] lat;
        logic               oe;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_SAMPLE: begin
                if (st_q.cnt == CNT_LAST) begin
                    st_d.lat = pins_i;     // latch closes here
                    st_d.ph  = PH_GAP;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_GAP: begin
                st_d.ph = PH_RUN;          // one idle cycle before driving
                st_d.oe = 1'b1;
            end
            PH_RUN: begin
                st_d.oe = 1'b1;
            end
            default: begin
                st_d.ph = PH_SAMPLE;
                st_d.oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_SAMPLE, cnt: '0, lat: '0, oe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.ph;
    assign latch_o = st_q.lat;
    assign oe_o    = st_q.oe;

endmodule

// File: rtl/code_sel.sv
module code_sel
    import strap_freq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  phase_e          phase_i,
    input  logic [FS_W-1:0] fs_i,
    input  logic [7:1]      ctrl_i,
    input  logic            hub_i,
    output logic [FS_W-1:0] code_o,
    output logic            sw_o,
    output logic            upd_o,
    output logic            spr_en_o,
    output logic            spr_dn_o,
    output logic            hub_o
);

    typedef struct packed {
        logic [FS_W-1:0] code;
        logic            sw;
        logic            upd;
        logic            spr_en;
        logic            spr_dn;
        logic            hub;
    } sel_t;

    sel_t s_d, s_q;

    logic [FS_W-1:0] sw_code;
    logic [FS_W-1:0] pick_code;
    logic            pick_sw;

    assign sw_code   = {ctrl_i[CB_SW_MSB], ctrl_i[CB_SW_B2],
                        ctrl_i[CB_SW_B1],  ctrl_i[CB_SW_B0]};
    assign pick_sw   = ctrl_i[CB_SRC_SEL];
    assign pick_code = pick_sw ? sw_code : fs_i;

    always_comb begin
        s_d        = s_q;
        s_d.spr_en = ctrl_i[CB_SPREAD_EN];
        s_d.spr_dn = ctrl_i[CB_SPREAD_DN];
        s_d.hub    = hub_i;
        s_d.upd    = 1'b0;
        case (phase_i)
            PH_GAP: begin
                s_d.code = pick_code;      // preload, no pulse
                s_d.sw   = pick_sw;
            end
            PH_RUN: begin
                s_d.code = pick_code;
                s_d.sw   = pick_sw;
                s_d.upd  = (pick_code != s_q.code) || (pick_sw != s_q.sw);
            end
            default: begin
                s_d.code = '0;
                s_d.sw   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o   = s_q.code;
    assign sw_o     = s_q.sw;
    assign upd_o    = s_q.upd;
    assign spr_en_o = s_q.spr_en;
    assign spr_dn_o = s_q.spr_dn;
    assign hub_o    = s_q.hub;

endmodule

// File: rtl/strap_freq_select.sv
module strap_freq_select
    import strap_freq_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic         clk_ref_i,
    input  logic         por_n_i,
    input  logic [4:0]   pad_level_i,
    input  logic [7:1]   ctrl0_i,
    input  logic         hub_sel_i,
    output logic         pad_oe_o,
    output logic [3:0]   freq_code_o,
    output logic         code_src_sw_o,
    output logic         code_upd_o,
    output logic         spread_en_o,
    output logic         spread_down_o,
    output logic         hub_sel_o,
    output logic         usb_sel_o,
    output logic [3:0]   fs_readback_o
);

    phase_e             phase;
    logic [STRAP_W-1:0] strap_lat;

    strap_seq #(.RST_CYCLES(RST_CYCLES)) seq_i (
        .clk     (clk_ref_i),
        .rst_n   (por_n_i),
        .pins_i  (pad_level_i),
        .phase_o (phase),
        .latch_o (strap_lat),
        .oe_o    (pad_oe_o)
    );

    code_sel sel_i (
        .clk      (clk_ref_i),
        .rst_n    (por_n_i),
        .phase_i  (phase),
        .fs_i     (strap_lat[FS_W-1:0]),
        .ctrl_i   (ctrl0_i),
        .hub_i    (hub_sel_i),
        .code_o   (freq_code_o),
        .sw_o     (code_src_sw_o),
        .upd_o    (code_upd_o),
        .spr_en_o (spread_en_o),
        .spr_dn_o (spread_down_o),
        .hub_o    (hub_sel_o)
    );

    assign usb_sel_o     = strap_lat[FS_W];
    assign fs_readback_o = ~strap_lat[FS_W-1:0];

endmodule

// File: rtl/strap_freq_select_chk.sv
module strap_freq_select_chk (
    input logic       clk_ref_i,
    input logic       por_n_i,
    input logic [7:1] ctrl0_i,
    input logic       pad_oe_o,
    input logic [3:0] freq_code_o,
    input logic       code_src_sw_o,
    input logic       code_upd_o,
    input logic       usb_sel_o,
    input logic [3:0] fs_readback_o
);

    assert_oe_hold_R1: assert property (@(posedge clk_ref_i) disable iff (!por_n_i)
        pad_oe_o |=> pad_oe_o);

    assert_strap_frozen_R2: assert property (@(posedge clk_ref_i) disable iff (!por_n_i)
        pad_oe_o |-> ($stable(fs_readback_o) && $stable(usb_sel_o)));

    assert_hw_code_R4: assert property (@(posedge clk_ref_i) disable iff (!por_n_i)
        (pad_oe_o && !code_src_sw_o) |-> (freq_code_o == ~fs_readback_o));

    assert_sw_code_R5: assert property (@(posedge clk_ref_i) disable iff (!por_n_i)
        (pad_oe_o && $past(pad_oe_o) && code_src_sw_o) |->
        (freq_code_o == {$past(ctrl0_i[2]), $past(ctrl0_i[6]),
                         $past(ctrl0_i[5]), $past(ctrl0_i[4])}));

    assert_pulse_on_change_R6: assert property (@(posedge clk_ref_i) disable iff (!por_n_i)
        (pad_oe_o && $past(pad_oe_o) &&
         (!$stable(freq_code_o) || !$stable(code_src_sw_o))) |-> code_upd_o);

    assert_no_spurious_pulse_R6: assert property (@(posedge clk_ref_i) disable iff (!por_n_i)
        code_upd_o |-> (!$stable(freq_code_o) || !$stable(code_src_sw_o)));

    assert_quiet_before_run_R9: assert property (@(posedge clk_ref_i) disable iff (!por_n_i)
        code_upd_o |-> $past(pad_oe_o));

endmodule

bind strap_freq_select strap_freq_select_chk chk_i (
    .clk_ref_i     (clk_ref_i),
    .por_n_i       (por_n_i),
    .ctrl0_i       (ctrl0_i),
    .pad_oe_o      (pad_oe_o),
    .freq_code_o   (freq_code_o),
    .code_src_sw_o (code_src_sw_o),
    .code_upd_o    (code_upd_o),
    .usb_sel_o     (usb_sel_o),
    .fs_readback_o (fs_readback_o)
);

// File: tb/strap_freq_select_tb.sv
module strap_freq_select_tb_top;

    localparam int TC = 16;

    logic       clk = 1'b0;
    logic       por_n;
    logic [4:0] pads;
    logic [7:1] ctrl;
    logic       hub;

    logic       oe, src, upd, spr_en, spr_dn, hub_o, usb;
    logic [3:0] code, rb;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [4:0] strap;
    logic [3:0] prev_code;
    logic       prev_sw;

    always #2 clk = ~clk;

    strap_freq_select #(.RST_CYCLES(TC)) dut_i (
        .clk_ref_i     (clk),
        .por_n_i       (por_n),
        .pad_level_i   (pads),
        .ctrl0_i       (ctrl),
        .hub_sel_i     (hub),
        .pad_oe_o      (oe),
        .freq_code_o   (code),
        .code_src_sw_o (src),
        .code_upd_o    (upd),
        .spread_en_o   (spr_en),
        .spread_down_o (spr_dn),
        .hub_sel_o     (hub_o),
        .usb_sel_o     (usb),
        .fs_readback_o (rb)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] model_code(logic [7:0] c, logic [4:0] s);
        return c[3] ? {c[2], c[6], c[5], c[4]} : s[3:0];
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // strap window: pads move one cycle before and one cycle after capture
    task automatic power_up(logic [4:0] before_v, logic [4:0] cap_v, logic [4:0] after_v);
        @(negedge clk);
        ctrl  = '0;
        pads  = before_v;
        por_n = 1'b1;
        for (int k = 1; k <= TC; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R1 oe low in strap window", oe, 0);
            check("R9 no pulse before enable", upd, 0);
            check("R9 code zero before enable", code, 0);
            if (k == TC - 1) pads = cap_v;
            if (k == TC)     pads = after_v;
        end
        @(posedge clk);
        @(negedge clk);
        strap = cap_v;
        check("R1 oe rises", oe, 1);
        check("R9 first enabled cycle no pulse", upd, 0);
        check("R4 hw code at enable", code, cap_v[3:0]);
        check("R2 capture edge value", usb, cap_v[4]);
        check("R3 readback inverted", rb, ~cap_v[3:0] & 4'hF);
        prev_code = cap_v[3:0];
        prev_sw   = 1'b0;
    endtask

    task automatic step(logic [7:0] c, logic h);
        logic [3:0] ec;
        logic       eu;
        ctrl = c[7:1];
        hub  = h;
        pads = 5'($urandom);
        @(posedge clk);
        @(negedge clk);
        ec = model_code(c, strap);
        eu = (ec != prev_code) || (c[3] != prev_sw);
        check("R4/R5 code", code, ec);
        if (c[3]) check("R5 source sw", src, 1);
        else      check("R4 source hw", src, 0);
        check("R6 update pulse", upd, eu);
        check("R7 spread enable", spr_en, c[1]);
        check("R7 spread mode", spr_dn, c[7]);
        check("R8 hub select", hub_o, h);
        check("R8 usb select", usb, strap[4]);
        check("R2 pads ignored", rb, ~strap[3:0] & 4'hF);
        check("R1 oe held", oe, 1);
        prev_code = ec;
        prev_sw   = c[3];
    endtask

    task automatic random_steps(int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] c;
            logic       h;
            int         hold;
            c    = 8'($urandom);
            h    = 1'($urandom);
            hold = 1 + ($urandom % 3);
            for (int j = 0; j < hold; j++) step(c, h);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        por_n = 1'b0;
        pads  = 5'h00;
        ctrl  = '0;
        hub   = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset oe", oe, 0);
        check("R9 reset code", code, 0);
        check("R9 reset pulse", upd, 0);

        power_up(5'h0A, 5'h16, 5'h09);

        // directed: sw=0, change only software field bits -> no pulse
        step(8'b0111_0000, 1'b1);
        step(8'b0000_0000, 1'b0);
        // switch to software code 0b1011 (bit2=1, bit6=0, bit5=1, bit4=1)
        step(8'b0011_1100, 1'b0);
        // same-cycle source flip back and field change
        step(8'b0100_0010, 1'b1);
        // software code equal to strap code 0110: only source changes
        step(8'b0110_1000, 1'b0);
        step(8'b0110_1000, 1'b0);
        // spread bits alone: no pulse
        step(8'b1110_1010, 1'b1);

        random_steps(150);

        // asynchronous reset mid-run
        @(negedge clk);
        #1 por_n = 1'b0;
        #0.5;
        check("R1 oe drops in reset", oe, 0);
        check("R9 code cleared in reset", code, 0);
        repeat (2) @(negedge clk);

        power_up(5'h1F, 5'h09, 5'h16);
        random_steps(150);
        step(8'b0000_0000, 1'b0);
        step(8'b0000_1000, 1'b0);  // software code 0000 vs strap 1001

        finish_run();
    end

endmodule